// File: doc/BRIEF.md
# Single-Wire Pulse-Width Serial Transmitter

This block drives one open-drain wire that carries commands to a peripheral. Time on the wire is divided into fixed bit cells of four microseconds. Each cell opens with the wire being pulled low. The value of the bit is carried by how long the wire stays low: one microsecond for a 1 and three microseconds for a 0. For the rest of the cell the wire is released and pulled high by the external resistor. The block never drives the wire high. It pulls the wire low by asserting `line_oe` and releases it by clearing `line_oe`.

A frame begins with a `start` pulse that carries the number of bytes to send. The bytes come in through a valid/ready handshake. Each byte is sent most significant bit first, and consecutive bytes follow with no idle time between them. After the last cell the block sends a stop bit, which is one microsecond low followed by release. It then pulses `done`. All timing is counted in system clocks, and the number of clocks per microsecond is a parameter.

If the next byte is not offered in the clock where it is needed, the frame is cut short. The block flags `underrun` and sends the stop bit straight away.

Top module: `pw_line_tx`

## Requirements
- R1: After reset `line_oe`, `busy`, `done`, `underrun` and `byte_ready` are all 0. `line_oe` is 1 only while the block is busy.
- R2: A data bit of value 1 is sent as `line_oe`=1 for CLK_PER_US clocks (16) and then `line_oe`=0 for 3*CLK_PER_US clocks (48).
- R3: A data bit of value 0 is sent as `line_oe`=1 for 3*CLK_PER_US clocks (48) and then `line_oe`=0 for CLK_PER_US clocks (16).
- R4: Bits go out most significant first (bit 7 down to bit 0). Every cell is exactly 4*CLK_PER_US clocks long and starts with `line_oe` going to 1. The first cell starts in the clock right after the edge that accepts `start`.
- R5: While more bytes remain, `byte_ready` is 1 only in the final clock of a byte's last cell. A byte is taken when `byte_valid` and `byte_ready` are both 1, and its first cell follows with no gap. The first byte is taken together with an accepted `start`.
- R6: After the last data cell, `line_oe` is 1 for CLK_PER_US clocks (stop bit). In the next clock `line_oe` is 0, `done` is 1 for that one clock, and `busy` is 0.
- R7: A `start` with `frame_len` = 0 produces no `line_oe` pulse. It gives `done`=1 in the next clock with `busy` staying 0, and clears `underrun`.
- R8: If `byte_valid` is 0 when a byte handoff is due, `underrun` goes to 1 and the stop bit begins at once. `underrun` holds until the next `start` is accepted.
- R9: `start` is ignored while `busy` is 1. The frame in progress continues unchanged.
- R10: If `byte_valid` is 0 when a non-zero-length `start` is accepted, only the stop bit is sent and `underrun` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| frame_len | input | LEN_W | Number of bytes in the frame |
| byte_valid | input | 1 | Next byte is present on `byte_data` |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Byte is taken at this edge if valid |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when a frame ends |
| underrun | output | 1 | Last frame ended early for lack of a byte |

## Verification
The bench builds the block with the default CLK_PER_US of 16 and LEN_W of 8, so the waveform it checks has the real 16/48/64-clock proportions. Every clock of the expected wire pattern is compared, including the stop bit. The 8-bit length makes zero-length, single-byte and multi-byte frames easy to reach, along with short-supplied frames that underrun either mid-frame or before the first cell. A stray `start` pulse is injected in the middle of one frame to confirm it has no effect.

// File: rtl/pw_line_pkg.sv
package pw_line_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_STOP = 2'd3
  } pw_phase_e;
endpackage

// File: rtl/pw_cell_timer.sv
module pw_cell_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt_q == '0));
endmodule

// File: rtl/pw_bit_shifter.sv
module pw_bit_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         advance,
  output logic         cur_bit,
  output logic         next_bit,
  output logic         last_bit
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_byte;
      idx_q <= IW'(W - 1);
    end else if (advance) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      idx_q <= idx_q - 1'b1;
    end
  end

  assign cur_bit  = sh_q[W-1];
  assign next_bit = sh_q[W-2];
  assign last_bit = (idx_q == '0);

  // R4
  shift_bound_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> (idx_q != '0));
endmodule

// File: rtl/pw_frame_ctrl.sv
module pw_frame_ctrl
  import pw_line_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned CW         = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             byte_valid,
  input  logic             in_msb,
  output logic             byte_ready,
  input  logic             timer_expired,
  output logic             timer_load,
  output logic [CW-1:0]    timer_val,
  output logic             sh_load,
  output logic             sh_advance,
  input  logic             cur_bit,
  input  logic             next_bit,
  input  logic             last_bit,
  output logic             line_oe,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  localparam int unsigned SHORT_CLK = CLK_PER_US;
  localparam int unsigned LONG_CLK  = 3 * CLK_PER_US;
  localparam int unsigned CELL_CLK  = 4 * CLK_PER_US;
  localparam logic [CW-1:0] LO_ONE  = CW'(SHORT_CLK - 1);
  localparam logic [CW-1:0] LO_ZERO = CW'(LONG_CLK - 1);
  localparam logic [CW-1:0] HI_ONE  = CW'(CELL_CLK - SHORT_CLK - 1);
  localparam logic [CW-1:0] HI_ZERO = CW'(CELL_CLK - LONG_CLK - 1);
  localparam logic [CW-1:0] STOP_LO = CW'(SHORT_CLK - 1);

  pw_phase_e        ph_q, ph_n;
  logic             oe_q, oe_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             und_q, und_n;
  logic [LEN_W-1:0] left_q, left_n;
  logic             idle_accept, take_mid;

  function automatic logic [CW-1:0] low_len(input logic b);
    return b ? LO_ONE : LO_ZERO;
  endfunction

  function automatic logic [CW-1:0] high_len(input logic b);
    return b ? HI_ONE : HI_ZERO;
  endfunction

  assign idle_accept = (ph_q == PH_IDLE) && start && (frame_len != '0);
  assign take_mid    = (ph_q == PH_HIGH) && timer_expired && last_bit && (left_q != '0);
  assign byte_ready  = idle_accept || take_mid;

  always_comb begin
    ph_n       = ph_q;
    oe_n       = oe_q;
    busy_n     = busy_q;
    done_n     = 1'b0;
    und_n      = und_q;
    left_n     = left_q;
    timer_load = 1'b0;
    timer_val  = '0;
    sh_load    = 1'b0;
    sh_advance = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          und_n = 1'b0;
          if (frame_len == '0) begin
            done_n = 1'b1;
          end else begin
            busy_n     = 1'b1;
            oe_n       = 1'b1;
            left_n     = frame_len - 1'b1;
            timer_load = 1'b1;
            if (byte_valid) begin
              sh_load   = 1'b1;
              timer_val = low_len(in_msb);
              ph_n      = PH_LOW;
            end else begin
              und_n     = 1'b1;
              timer_val = STOP_LO;
              ph_n      = PH_STOP;
            end
          end
        end
      end
      PH_LOW: begin
        if (timer_expired) begin
          oe_n       = 1'b0;
          timer_load = 1'b1;
          timer_val  = high_len(cur_bit);
          ph_n       = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (timer_expired) begin
          oe_n       = 1'b1;
          timer_load = 1'b1;
          if (!last_bit) begin
            sh_advance = 1'b1;
            timer_val  = low_len(next_bit);
            ph_n       = PH_LOW;
          end else if (left_q == '0) begin
            timer_val  = STOP_LO;
            ph_n       = PH_STOP;
          end else if (byte_valid) begin
            sh_load    = 1'b1;
            left_n     = left_q - 1'b1;
            timer_val  = low_len(in_msb);
            ph_n       = PH_LOW;
          end else begin
            und_n      = 1'b1;
            timer_val  = STOP_LO;
            ph_n       = PH_STOP;
          end
        end
      end
      PH_STOP: begin
        if (timer_expired) begin
          oe_n   = 1'b0;
          busy_n = 1'b0;
          done_n = 1'b1;
          ph_n   = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      und_q  <= 1'b0;
      left_q <= '0;
    end else begin
      ph_q   <= ph_n;
      oe_q   <= oe_n;
      busy_q <= busy_n;
      done_q <= done_n;
      und_q  <= und_n;
      left_q <= left_n;
    end
  end

  assign line_oe  = oe_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign underrun = und_q;

  // R1
  oe_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> busy_q);
  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!oe_q && !busy_q));
  // R6
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_IDLE) && start && (frame_len == '0)) |=> (done_q && !oe_q && !busy_q));
  // R8
  underrun_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(und_q) |-> oe_q);
  // R5
  handoff_cell_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_ready && byte_valid) |=> (oe_q && (ph_q == PH_LOW)));
endmodule

// File: rtl/pw_line_tx.sv
module pw_line_tx
  import pw_line_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             line_oe,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  localparam int unsigned CW = $clog2(4 * CLK_PER_US);

  logic          t_load, t_expired;
  logic [CW-1:0] t_val;
  logic          s_load, s_adv, s_cur, s_next, s_last;

  pw_cell_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  pw_bit_shifter #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (s_load),
    .load_byte (byte_data),
    .advance   (s_adv),
    .cur_bit   (s_cur),
    .next_bit  (s_next),
    .last_bit  (s_last)
  );

  pw_frame_ctrl #(
    .CLK_PER_US (CLK_PER_US),
    .LEN_W      (LEN_W),
    .CW         (CW)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .frame_len     (frame_len),
    .byte_valid    (byte_valid),
    .in_msb        (byte_data[BYTE_W-1]),
    .byte_ready    (byte_ready),
    .timer_expired (t_expired),
    .timer_load    (t_load),
    .timer_val     (t_val),
    .sh_load       (s_load),
    .sh_advance    (s_adv),
    .cur_bit       (s_cur),
    .next_bit      (s_next),
    .last_bit      (s_last),
    .line_oe       (line_oe),
    .busy          (busy),
    .done          (done),
    .underrun      (underrun)
  );
endmodule

// File: tb/pw_line_tx_bench.sv
module pw_line_tx_bench;
  localparam int CPU  = 16;
  localparam int T_S  = CPU;
  localparam int T_L  = 3 * CPU;
  localparam int T_C  = 4 * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] frame_len = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_ready, line_oe, busy, done, underrun;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_wave [0:8191];
  logic [7:0] buf_q [0:15];

  always #5 clk = ~clk;

  pw_line_tx #(.CLK_PER_US(CPU), .LEN_W(8)) u_pw_line_tx (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .line_oe(line_oe), .busy(busy), .done(done), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int build_wave(input int len, input int avail);
    int pos = 0;
    int nb  = (avail < len) ? avail : len;
    for (int i = 0; i < nb; i++) begin
      for (int b = 7; b >= 0; b--) begin
        int lo = buf_q[i][b] ? T_S : T_L;
        for (int k = 0; k < T_C; k++) begin
          exp_wave[pos] = (k < lo);
          pos++;
        end
      end
    end
    if (len > 0) begin
      for (int k = 0; k < T_S; k++) begin
        exp_wave[pos] = 1'b1;
        pos++;
      end
    end
    return pos;
  endfunction

  task automatic run_frame(input int len, input int avail, input bit poke,
                           input string req);
    int pos;
    int idx = 0;
    bit take;
    int wave_bad = 0;
    int first_bad = -1;
    int act_bad = 0;
    int done_at = -1;
    bit und_at = 0;
    bit busy_at = 0;
    bit exp_bit;
    pos = build_wave(len, avail);
    @(negedge clk);
    start      = 1'b1;
    frame_len  = len[7:0];
    byte_valid = (avail > 0);
    byte_data  = buf_q[0];
    take       = (len > 0) && (avail > 0);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < pos + 100; c++) begin
      if (take) begin
        idx++;
        byte_valid = (idx < avail);
        byte_data  = (idx < 16) ? buf_q[idx] : 8'h00;
      end
      if (poke && c == 100) begin
        start     = 1'b1;
        frame_len = 8'd0;
      end else begin
        start = 1'b0;
      end
      exp_bit = (c < pos) ? exp_wave[c] : 1'b0;
      if (line_oe !== exp_bit) begin
        wave_bad++;
        if (first_bad < 0) begin
          first_bad = c;
          act_bad   = int'(line_oe);
        end
      end
      if (c == 0 && len > 0)
        check(busy === 1'b1, "R4", "busy in first cell clock", int'(busy), 1);
      if (done === 1'b1) begin
        done_at = c;
        und_at  = underrun;
        busy_at = busy;
        break;
      end
      take = (byte_ready === 1'b1) && byte_valid;
      @(negedge clk);
    end
    start      = 1'b0;
    byte_valid = 1'b0;
    check(wave_bad == 0, req, $sformatf("wire pattern, first bad clock %0d", first_bad),
          act_bad, first_bad < 0 ? act_bad : int'(exp_wave[first_bad]));
    check(done_at == pos, "R6", "clock of done pulse", done_at, pos);
    check(und_at == ((len > 0) && (avail < len)), "R8", "underrun at done",
          int'(und_at), int'((len > 0) && (avail < len)));
    check(busy_at == 1'b0, "R6", "busy at done", int'(busy_at), 0);
    @(negedge clk);
    check(done === 1'b0 && line_oe === 1'b0, "R6", "done one clock, line released",
          int'(done) + int'(line_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual 200000 cycles expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(line_oe === 1'b0 && busy === 1'b0 && done === 1'b0 &&
          underrun === 1'b0 && byte_ready === 1'b0, "R1", "outputs after reset",
          int'({line_oe, busy, done, underrun, byte_ready}), 0);

    buf_q[0] = 8'hFF; run_frame(1, 1, 0, "R2");
    buf_q[0] = 8'h00; run_frame(1, 1, 0, "R3");
    buf_q[0] = 8'hA5; run_frame(1, 1, 0, "R4");
    buf_q[0] = 8'h80; buf_q[1] = 8'h01; buf_q[2] = 8'h3C;
    run_frame(3, 3, 0, "R5");
    buf_q[0] = 8'h5A; buf_q[1] = 8'hC3;
    run_frame(3, 1, 0, "R8");
    check(underrun === 1'b1, "R8", "underrun held while idle", int'(underrun), 1);
    run_frame(0, 0, 0, "R7");
    check(underrun === 1'b0, "R7", "underrun cleared by start", int'(underrun), 0);
    run_frame(2, 0, 0, "R10");
    buf_q[0] = 8'h96; buf_q[1] = 8'h0F;
    run_frame(2, 2, 1, "R9");
    check(underrun === 1'b0, "R9", "stray start left no underrun", int'(underrun), 0);

    for (int f = 0; f < 20; f++) begin
      int len = 1 + int'($urandom % 4);
      int avail = len;
      if (($urandom % 5) == 0) avail = int'($urandom % len);
      for (int i = 0; i < 16; i++) buf_q[i] = 8'($urandom);
      run_frame(len, avail, 0, (avail < len) ? "R8" : "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule